// File: doc/BRIEF.md
# Multiply Stage with Overflow Flag

This block is one execution stage of an integer multiply unit. It takes two operands of XLEN bits, the instruction word, a signedness control and a width control, and returns the low XLEN bits of the product. Alongside the product it returns a two-bit overflow field and an "ok" qualifier for that field. In full-width mode both operands are used whole. In word mode only the lower half of each operand is used, sign-extended for a signed multiply and zero-extended for an unsigned one. A signed product is formed from operand magnitudes, and the sign is then put back on the product.

Overflow means that the high part of the product is not a plain sign extension of the result. The flag is written only when the overflow-enable bit of the instruction is set. An opaque operation record and a mux identifier travel with each operation and come out unchanged with the result.

Both data edges use valid/ready. The stage holds one registered result. A new operation is accepted when the output register is empty or is being drained in the same cycle. While the output is valid and not taken, every output holds its value and the input is stalled.

Top module: `mul_ovf_stage`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. An operation accepted at a clock edge (`in_valid` and `in_ready` both high) appears on the outputs with `out_valid` high after that edge. With no operation accepted and `out_ready` high, `out_valid` falls.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` and all output data fields keep their values at each following edge.
- R3: In full mode (`in_word`=0), `out_result` is the low XLEN bits of a×b. With `in_signed`=1 both operands are read as two's complement; with `in_signed`=0 both are unsigned.
- R4: In word mode (`in_word`=1), each operand is first reduced to its low XLEN/2 bits. These bits are sign-extended when `in_signed`=1 and zero-extended when it is 0. `out_result` is the low XLEN bits of the product of the extended values.
- R5: In word mode, overflow is set when product bits XLEN/2−1 through XLEN−1 are neither all zeros nor all ones. For XLEN=64 that is bits 31 to 63.
- R6: In full mode, overflow is set when bits XLEN−1 through 2·XLEN−1 of the 2·XLEN-bit two's-complement product are neither all zeros nor all ones.
- R7: Both bits of `out_ov` carry the same overflow value.
- R8: When bit OE_BIT (default 10, bit 0 = LSB) of `in_insn` is 0, `out_ov_ok` is 0 and `out_ov` is 2'b00. No other bit of `in_insn` has any effect.
- R9: When bit OE_BIT of `in_insn` is 1, `out_ov_ok` is 1 and `out_ov` carries the overflow value from R5/R6.
- R10: `out_ctx` and `out_muxid` equal the `in_ctx` and `in_muxid` of the same accepted operation.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operation present |
| in_ready | output | 1 | Stage can take an operation |
| in_a | input | XLEN | First operand |
| in_b | input | XLEN | Second operand |
| in_insn | input | 32 | Instruction word; bit OE_BIT enables overflow reporting |
| in_signed | input | 1 | 1: two's-complement multiply |
| in_word | input | 1 | 1: half-width (word) mode |
| in_ctx | input | CTX_W | Operation record, passed through |
| in_muxid | input | MUXID_W | Mux identifier, passed through |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | XLEN | Low XLEN bits of the product |
| out_ov | output | 2 | Overflow flag, duplicated |
| out_ov_ok | output | 1 | Overflow field is to be written |
| out_ctx | output | CTX_W | Operation record of this result |
| out_muxid | output | MUXID_W | Mux identifier of this result |

## Verification
The bench builds the stage with XLEN=6, so word mode works on 3-bit halves, and it uses CTX_W=4 and MUXID_W=2. At that size every operand pair can be streamed through, one per cycle, in all four signedness and width combinations. This covers every sign-extension boundary of both overflow windows, including the most negative operand times itself. The overflow-enable bit is varied across the sweep. A short stall sequence covers back-pressure, hold and drain.

// File: rtl/mul_ovf_pkg.sv
package mul_ovf_pkg;
  typedef enum logic {
    WIDTH_FULL = 1'b0,
    WIDTH_WORD = 1'b1
  } width_mode_e;

  localparam int OV_FIELD_W = 2;

  // true when a bit window is a pure sign extension (all equal)
  function automatic logic uniform(input logic [127:0] bits, input int n);
    logic ones;
    logic zeros;
    ones  = 1'b1;
    zeros = 1'b1;
    for (int i = 0; i < 128; i++) begin
      if (i < n) begin
        ones  = ones & bits[i];
        zeros = zeros & ~bits[i];
      end
    end
    return ones | zeros;
  endfunction
endpackage

// File: rtl/mul_ovf_prep.sv
module mul_ovf_prep
  import mul_ovf_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] op_i,
  input  logic            signed_i,
  input  width_mode_e     mode_i,
  output logic [XLEN-1:0] mag_o,
  output logic            neg_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] ext;

  always_comb begin
    if (mode_i == WIDTH_WORD) begin
      if (signed_i) ext = {{(XLEN-HALF){op_i[HALF-1]}}, op_i[HALF-1:0]};
      else          ext = {{(XLEN-HALF){1'b0}}, op_i[HALF-1:0]};
    end else begin
      ext = op_i;
    end
    neg_o = signed_i & ext[XLEN-1];
    mag_o = neg_o ? (~ext + 1'b1) : ext;
  end

  // an unsigned operand never carries a sign (R3)
  always_comb begin
    if (!signed_i) begin
      p_unsigned_pos_r3: assert (!neg_o);
    end
  end
endmodule

// File: rtl/mul_ovf_core.sv
module mul_ovf_core #(
  parameter int XLEN = 64,
  localparam int PW = 2 * XLEN
) (
  input  logic [XLEN-1:0] mag_a_i,
  input  logic [XLEN-1:0] mag_b_i,
  input  logic            neg_a_i,
  input  logic            neg_b_i,
  output logic [PW-1:0]   prod_o
);
  logic [PW-1:0] umag;
  logic          neg;

  always_comb begin
    umag   = {{XLEN{1'b0}}, mag_a_i} * {{XLEN{1'b0}}, mag_b_i};
    neg    = neg_a_i ^ neg_b_i;
    prod_o = neg ? (~umag + 1'b1) : umag;
  end
endmodule

// File: rtl/mul_ovf_flag.sv
module mul_ovf_flag
  import mul_ovf_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int OE_BIT = 10,
  localparam int PW    = 2 * XLEN,
  localparam int HALF  = XLEN / 2,
  localparam int WIN_H = XLEN - HALF + 1,
  localparam int WIN_F = XLEN + 1
) (
  input  logic [PW-1:0]         prod_i,
  input  width_mode_e           mode_i,
  input  logic [31:0]           insn_i,
  output logic [OV_FIELD_W-1:0] ov_o,
  output logic                  ok_o
);
  logic [127:0] win_h;
  logic [127:0] win_f;
  logic         ov;

  always_comb begin
    win_h = '0;
    win_f = '0;
    win_h[WIN_H-1:0] = prod_i[XLEN-1:HALF-1];
    win_f[WIN_F-1:0] = prod_i[PW-1:XLEN-1];
    if (mode_i == WIDTH_WORD) ov = ~uniform(win_h, WIN_H);
    else                      ov = ~uniform(win_f, WIN_F);
    ok_o = insn_i[OE_BIT];
  end

  for (genvar g = 0; g < OV_FIELD_W; g++) begin : g_dup
    assign ov_o[g] = ok_o & ov;
  end
endmodule

// File: rtl/mul_ovf_stage.sv
module mul_ovf_stage
  import mul_ovf_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int OE_BIT  = 10,
  parameter int CTX_W   = 16,
  parameter int MUXID_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [XLEN-1:0]    in_a,
  input  logic [XLEN-1:0]    in_b,
  input  logic [31:0]        in_insn,
  input  logic               in_signed,
  input  logic               in_word,
  input  logic [CTX_W-1:0]   in_ctx,
  input  logic [MUXID_W-1:0] in_muxid,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [XLEN-1:0]    out_result,
  output logic [1:0]         out_ov,
  output logic               out_ov_ok,
  output logic [CTX_W-1:0]   out_ctx,
  output logic [MUXID_W-1:0] out_muxid
);
  localparam int PW = 2 * XLEN;

  width_mode_e               mode;
  logic [1:0][XLEN-1:0]      ops;
  logic [1:0][XLEN-1:0]      mags;
  logic [1:0]                negs;
  logic [PW-1:0]             prod;
  logic [OV_FIELD_W-1:0]     ov_c;
  logic                      ok_c;
  logic                      accept;

  assign mode   = in_word ? WIDTH_WORD : WIDTH_FULL;
  assign ops[0] = in_a;
  assign ops[1] = in_b;

  for (genvar g = 0; g < 2; g++) begin : g_prep
    mul_ovf_prep #(.XLEN(XLEN)) prep_i (
      .op_i    (ops[g]),
      .signed_i(in_signed),
      .mode_i  (mode),
      .mag_o   (mags[g]),
      .neg_o   (negs[g])
    );
  end

  mul_ovf_core #(.XLEN(XLEN)) core_i (
    .mag_a_i(mags[0]),
    .mag_b_i(mags[1]),
    .neg_a_i(negs[0]),
    .neg_b_i(negs[1]),
    .prod_o (prod)
  );

  mul_ovf_flag #(.XLEN(XLEN), .OE_BIT(OE_BIT)) flag_i (
    .prod_i(prod),
    .mode_i(mode),
    .insn_i(in_insn),
    .ov_o  (ov_c),
    .ok_o  (ok_c)
  );

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ov     <= '0;
      out_ov_ok  <= 1'b0;
      out_ctx    <= '0;
      out_muxid  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= prod[XLEN-1:0];
        out_ov     <= ov_c;
        out_ov_ok  <= ok_c;
        out_ctx    <= in_ctx;
        out_muxid  <= in_muxid;
      end
    end
  end

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
      $stable(out_ov) && $stable(out_ov_ok) && $stable(out_ctx) && $stable(out_muxid));

  p_empty_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_ov_dup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_ov[0] == out_ov[1]);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ov_ok |-> out_ov == 2'b00);

  p_ctx_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_ctx == $past(in_ctx) && out_muxid == $past(in_muxid));
endmodule

// File: tb/mul_ovf_stage_tb_top.sv
module mul_ovf_stage_tb_top;
  localparam int XLEN = 6;
  localparam int CW   = 4;
  localparam int MW   = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [XLEN-1:0] in_a = '0;
  logic [XLEN-1:0] in_b = '0;
  logic [31:0]     in_insn = '0;
  logic            in_signed = 1'b0;
  logic            in_word = 1'b0;
  logic [CW-1:0]   in_ctx = '0;
  logic [MW-1:0]   in_muxid = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [XLEN-1:0] out_result;
  logic [1:0]      out_ov;
  logic            out_ov_ok;
  logic [CW-1:0]   out_ctx;
  logic [MW-1:0]   out_muxid;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mul_ovf_stage #(.XLEN(XLEN), .OE_BIT(10), .CTX_W(CW), .MUXID_W(MW)) dut_i (
    .clk, .rst_n, .in_valid, .in_ready, .in_a, .in_b, .in_insn, .in_signed,
    .in_word, .in_ctx, .in_muxid, .out_valid, .out_ready, .out_result,
    .out_ov, .out_ov_ok, .out_ctx, .out_muxid
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected values computed arithmetically
  int e_res, e_ov, e_ok, e_ctx, e_mux, e_word;

  task automatic expect_for(input int a, input int b, input bit sg, input bit wd,
                            input bit oe, input int cx, input int mx);
    int va, vb, p, p12, f;
    bit ov;
    if (wd) begin
      va = a & 7; vb = b & 7;
      if (sg && va >= 4) va -= 8;
      if (sg && vb >= 4) vb -= 8;
    end else begin
      va = a; vb = b;
      if (sg && va >= 32) va -= 64;
      if (sg && vb >= 32) vb -= 64;
    end
    p   = va * vb;
    p12 = p & 4095;
    if (wd) begin f = (p12 >> 2) & 15;  ov = (f != 0) && (f != 15);  end
    else    begin f = (p12 >> 5) & 127; ov = (f != 0) && (f != 127); end
    e_res  = p & 63;
    e_ok   = oe;
    e_ov   = oe ? (ov ? 3 : 0) : 0;
    e_ctx  = cx;
    e_mux  = mx;
    e_word = wd;
  endtask

  task automatic drive(input int a, input int b, input bit sg, input bit wd,
                       input bit oe, input int cx, input int mx);
    logic [31:0] w;
    w = oe ? 32'hA5A5_A5A5 | 32'h400 : 32'h5A5A_5A5A & ~32'h400;
    in_valid  = 1'b1;
    in_a      = XLEN'(a);
    in_b      = XLEN'(b);
    in_signed = sg;
    in_word   = wd;
    in_insn   = w;
    in_ctx    = CW'(cx);
    in_muxid  = MW'(mx);
  endtask

  task automatic check_out();
    chk("R1 out_valid", 32'(out_valid), 1);
    if (e_word) begin
      chk("R4 result", 32'(out_result), e_res);
      chk("R5 ov", 32'(out_ov), e_ov);
    end else begin
      chk("R3 result", 32'(out_result), e_res);
      chk("R6 ov", 32'(out_ov), e_ov);
    end
    chk(e_ok ? "R9 ov_ok" : "R8 ov_ok", 32'(out_ov_ok), e_ok);
    chk("R10 ctx", {26'd0, out_muxid, out_ctx}, (e_mux << 4) | e_ctx);
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 out_valid", 32'(out_valid), 0);
    chk("R11 in_ready", 32'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // exhaustive sweep, one operation per cycle
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 64; a++) begin
        for (int b = 0; b < 64; b++) begin
          bit oe;
          oe = bit'(((a * 7 + b + m) >> 1) & 1);
          drive(a, b, m[0], m[1], oe, (a ^ b) & 15, b & 3);
          @(negedge clk);
          expect_for(a, b, m[0], m[1], oe, (a ^ b) & 15, b & 3);
          check_out();
          chk("R7 dup", 32'(out_ov[0]), 32'(out_ov[1]));
        end
      end
    end

    // back-pressure: X held while stalled, Y follows
    drive(32, 32, 1'b1, 1'b0, 1'b1, 5, 1);
    @(negedge clk);
    expect_for(32, 32, 1'b1, 1'b0, 1'b1, 5, 1);
    check_out();
    out_ready = 1'b0;
    drive(3, 63, 1'b0, 1'b1, 1'b1, 9, 2);
    #1;
    chk("R1 stall in_ready", 32'(in_ready), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2 hold valid", 32'(out_valid), 1);
      chk("R2 hold result", 32'(out_result), e_res);
      chk("R2 hold ov", 32'(out_ov), e_ov);
      chk("R2 hold ctx", {26'd0, out_muxid, out_ctx}, (e_mux << 4) | e_ctx);
    end
    out_ready = 1'b1;
    #1;
    chk("R1 drain in_ready", 32'(in_ready), 1);
    @(negedge clk);
    expect_for(3, 63, 1'b0, 1'b1, 1'b1, 9, 2);
    check_out();
    in_valid = 1'b0;
    @(negedge clk);
    chk("R1 empty out_valid", 32'(out_valid), 0);
    chk("R1 empty in_ready", 32'(in_ready), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule